// File: doc/BRIEF.md
# Internal Data RAM with Address-Mode Router

This block holds the 256-byte on-core data RAM of an 8-bit microcontroller core and decides, for every access, which storage the address really names. One request carries an address, a two-bit addressing-mode code, a write flag and write data. The block answers reads in the same cycle and commits writes on the next rising clock edge. The same upper half of the address range means two different things. With direct addressing it names the special-function register bus, which this block only forwards to. With indirect addressing it names the upper 128 bytes of RAM.

Register names R0..R7 resolve through one of four banks of eight bytes at the bottom of the RAM. The bank is picked by two status-word bits that a neighbour presents and this block latches. Indirect accesses take their pointer from R0 or R1 of the active bank. A 16-byte window starting at 0x20 is also reachable one bit at a time. A bit write is a masked write of the containing byte and completes in one cycle.

Requests use valid/ready. Accesses that stay in RAM are always accepted. Accesses routed to the special-function register bus are accepted only when that bus is ready. A write commits only in a cycle where valid and ready are both high. The read data is meaningful in that same cycle.

Top module: `iram_router`

## Requirements
- R1: With mode code 2'b00 (direct) and an address below 0x80, a write of a byte changes the RAM at that address from the next rising edge, and a read returns the stored byte combinationally on `rd_data`.
- R2: With mode code 2'b11 (register), `req_addr[2:0]` names register n and the access goes to RAM byte bank*8 + n; bank = {RS1, RS0} as last loaded from `bank_bits` (status-word bits 4 and 3) on a cycle with `bank_ld` high. The bank is unchanged on every other cycle.
- R3: A synchronous reset sets the latched bank to 0 and leaves all RAM contents unchanged.
- R4: With mode code 2'b01 (indirect), `req_addr[0]` selects R0 (0) or R1 (1) of the active bank as the pointer. The access goes to RAM at the pointer's value over the full range 0x00..0xFF and never raises `sfr_valid`.
- R5: With mode code 2'b00 and an address of 0x80 or above, the access is forwarded. `sfr_valid` is high, and `sfr_addr`, `sfr_we` and `sfr_wdata` carry the request. `rd_data` returns `sfr_rdata`, and no RAM byte changes.
- R6: With mode code 2'b10 (bit) and a bit address b below 0x80, the access names bit b & 7 of RAM byte 0x20 + (b >> 3). A read returns that bit in `rd_data[0]` with bits 7..1 zero. A write stores `req_wdata[0]` and ignores bits 7..1.
- R7: A bit write leaves the other seven bits of its byte, and every other byte, unchanged.
- R8: With mode code 2'b10 and a bit address of 0x80 or above, the access is forwarded with `sfr_valid` and `sfr_bit` high and `sfr_addr` equal to the bit address. No RAM byte changes.
- R9: `req_ready` is 1 for any access that stays in RAM and equals `sfr_ready` for a forwarded access. With `req_valid` low, nothing is forwarded and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, clears the latched bank |
| bank_ld | input | 1 | Latch `bank_bits` at the next edge |
| bank_bits | input | 2 | Status-word bits 4:3 (RS1, RS0) |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access accepted this cycle |
| req_mode | input | 2 | 00 direct, 01 indirect, 10 bit, 11 register |
| req_addr | input | 8 | Address, bit address, register number or pointer select |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 8 | Write data (bit 0 only in bit mode) |
| rd_data | output | 8 | Read data, valid in the accepting cycle |
| sfr_valid | output | 1 | Forwarded access to the special-function register bus |
| sfr_ready | input | 1 | The register bus accepts the access |
| sfr_addr | output | 8 | Forwarded address |
| sfr_we | output | 1 | Forwarded write flag |
| sfr_bit | output | 1 | Forwarded access is a bit access |
| sfr_wdata | output | 8 | Forwarded write data |
| sfr_rdata | input | 8 | Register bus read data |

## Verification
The bench builds the block with its default parameters: an 8-bit address, four banks of eight registers and a 16-byte bit window at 0x20. With these values every direct and indirect address can be swept, along with every bank/register pair, all 128 RAM bit addresses and all 128 forwarded bit addresses. A bench model of the bit window catches any stray change to neighbouring bits or bytes. The register bus is modelled with a computed read value and a controllable ready, so back-pressure and the no-touch rules for forwarded accesses are checked.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT   = 2'b00,
    AM_INDIRECT = 2'b01,
    AM_BIT      = 2'b10,
    AM_REG      = 2'b11
  } amode_e;
endpackage

// File: rtl/iram_bank_sel.sv
// Latched register-bank selection; the only state cleared by reset.
module iram_bank_sel #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [BW-1:0] bits_in,
  output logic [BW-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (rst)     bank_q <= '0;
    else if (ld) bank_q <= bits_in;
  end
endmodule

// File: rtl/iram_addr_map.sv
// Resolves mode + address into a RAM location or a forwarded access.
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int BW       = 2,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic          valid,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] bank,
  input  logic [DW-1:0] ptr_val,
  input  logic [DW-1:0] byte_rd,
  input  logic [DW-1:0] sfr_rdata,
  input  logic          sfr_ready,
  output logic [AW-1:0] ptr_addr,
  output logic [AW-1:0] mem_addr,
  output logic          ram_we,
  output logic [DW-1:0] wr_mask,
  output logic [DW-1:0] wr_data,
  output logic          sfr_valid,
  output logic          sfr_bit,
  output logic          ready,
  output logic [DW-1:0] rd_data
);
  localparam int BIDX_W = $clog2(DW);

  logic [AW-1:0]     bank_base;
  logic [AW-1:0]     bit_byte;
  logic [BIDX_W-1:0] bit_idx;
  logic              to_sfr;
  logic              is_bit;
  logic              fire;

  assign bank_base = AW'(bank) << REG_W;
  assign ptr_addr  = bank_base + AW'(addr[0]);
  assign bit_byte  = AW'(BIT_BASE) + (addr >> BIDX_W);
  assign bit_idx   = addr[BIDX_W-1:0];

  always_comb begin
    mem_addr = addr;
    to_sfr   = 1'b0;
    is_bit   = 1'b0;
    case (amode_e'(mode))
      AM_DIRECT:   to_sfr = addr[AW-1];
      AM_INDIRECT: mem_addr = AW'(ptr_val);
      AM_BIT: begin
        if (addr[AW-1]) to_sfr = 1'b1;
        else begin
          is_bit   = 1'b1;
          mem_addr = bit_byte;
        end
      end
      default:     mem_addr = bank_base + AW'(addr[REG_W-1:0]);
    endcase
  end

  assign ready     = to_sfr ? sfr_ready : 1'b1;
  assign fire      = valid & ready;
  assign sfr_valid = valid & to_sfr;
  assign sfr_bit   = (amode_e'(mode) == AM_BIT);
  assign ram_we    = fire & we & ~to_sfr;
  assign wr_mask   = is_bit ? (DW'(1) << bit_idx) : '1;
  assign wr_data   = is_bit ? {DW{wdata[0]}} : wdata;

  always_comb begin
    if (to_sfr)      rd_data = sfr_rdata;
    else if (is_bit) rd_data = DW'(byte_rd[bit_idx]);
    else             rd_data = byte_rd;
  end
endmodule

// File: rtl/iram_array.sv
// Storage: two combinational read ports, one masked write port.
module iram_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_ptr,
  output logic [DW-1:0] rd_ptr,
  input  logic [AW-1:0] ra_data,
  output logic [DW-1:0] rd_dat,
  input  logic          we,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] wd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign rd_ptr = mem[ra_ptr];
  assign rd_dat = mem[ra_data];

  always_ff @(posedge clk) begin
    if (we) mem[ra_data] <= (mem[ra_data] & ~mask) | (wd & mask);
  end
endmodule

// File: rtl/iram_router.sv
module iram_router #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int NBANK    = 4,
  parameter int NREG     = 8,
  parameter int BIT_BASE = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bank_ld,
  input  logic [$clog2(NBANK)-1:0] bank_bits,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_mode,
  input  logic [AW-1:0]            req_addr,
  input  logic                     req_we,
  input  logic [DW-1:0]            req_wdata,
  output logic [DW-1:0]            rd_data,
  output logic                     sfr_valid,
  input  logic                     sfr_ready,
  output logic [AW-1:0]            sfr_addr,
  output logic                     sfr_we,
  output logic                     sfr_bit,
  output logic [DW-1:0]            sfr_wdata,
  input  logic [DW-1:0]            sfr_rdata
);
  localparam int BW    = $clog2(NBANK);
  localparam int REG_W = $clog2(NREG);

  logic [BW-1:0] bank_q;
  logic [AW-1:0] ptr_addr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] ptr_val;
  logic [DW-1:0] mem_rd;
  logic          ram_we;
  logic [DW-1:0] wr_mask;
  logic [DW-1:0] wr_data;

  iram_bank_sel #(.BW(BW)) u_bank (
    .clk(clk), .rst(rst), .ld(bank_ld), .bits_in(bank_bits), .bank_q(bank_q)
  );

  iram_addr_map #(
    .AW(AW), .DW(DW), .BW(BW), .REG_W(REG_W), .BIT_BASE(BIT_BASE)
  ) u_map (
    .mode(req_mode), .addr(req_addr), .valid(req_valid), .we(req_we),
    .wdata(req_wdata), .bank(bank_q), .ptr_val(ptr_val), .byte_rd(mem_rd),
    .sfr_rdata(sfr_rdata), .sfr_ready(sfr_ready), .ptr_addr(ptr_addr),
    .mem_addr(mem_addr), .ram_we(ram_we), .wr_mask(wr_mask),
    .wr_data(wr_data), .sfr_valid(sfr_valid), .sfr_bit(sfr_bit),
    .ready(req_ready), .rd_data(rd_data)
  );

  iram_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .ra_ptr(ptr_addr), .rd_ptr(ptr_val), .ra_data(mem_addr),
    .rd_dat(mem_rd), .we(ram_we), .mask(wr_mask), .wd(wr_data)
  );

  assign sfr_addr  = req_addr;
  assign sfr_we    = req_we;
  assign sfr_wdata = req_wdata;
endmodule

// File: rtl/iram_chk.sv
module iram_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          bank_ld,
  input logic          req_valid,
  input logic [1:0]    req_mode,
  input logic [AW-1:0] req_addr,
  input logic          sfr_valid,
  input logic          sfr_bit,
  input logic          ram_we,
  input logic [DW-1:0] wr_mask,
  input logic [BW-1:0] bank_q
);
  // R5
  dir_upper_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b00 && req_addr[AW-1]) |-> (sfr_valid && !ram_we));
  // R4
  ind_local_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b01) |-> !sfr_valid);
  // R7
  bit_mask_one_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && req_mode == 2'b10) |-> ($countones(wr_mask) == 1));
  // R8
  bit_upper_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b10 && req_addr[AW-1]) |-> (sfr_valid && sfr_bit && !ram_we));
  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bank_ld |=> $stable(bank_q));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!sfr_valid && !ram_we));
endmodule

bind iram_router iram_chk #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .bank_ld(bank_ld), .req_valid(req_valid),
  .req_mode(req_mode), .req_addr(req_addr), .sfr_valid(sfr_valid),
  .sfr_bit(sfr_bit), .ram_we(ram_we), .wr_mask(wr_mask), .bank_q(bank_q)
);

// File: tb/test_iram_router.sv
`timescale 1ns/1ps
module test_iram_router;
  logic       clk = 0;
  logic       rst = 1;
  logic       bank_ld = 0;
  logic [1:0] bank_bits = 0;
  logic       req_valid = 0;
  logic       req_ready;
  logic [1:0] req_mode = 0;
  logic [7:0] req_addr = 0;
  logic       req_we = 0;
  logic [7:0] req_wdata = 0;
  logic [7:0] rd_data;
  logic       sfr_valid;
  logic       sfr_ready = 1;
  logic [7:0] sfr_addr;
  logic       sfr_we;
  logic       sfr_bit;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;

  int checks = 0;
  int fails = 0;
  int sfr_hits = 0;
  logic done = 0;

  logic       s_valid, s_we, s_bit, s_ready;
  logic [7:0] s_addr, s_wdata;
  logic [7:0] mdl [16];

  always #5 clk = ~clk;

  assign sfr_rdata = ~sfr_addr;

  always @(posedge clk) if (sfr_valid && sfr_ready) sfr_hits <= sfr_hits + 1;

  iram_router i_iram_router (
    .clk(clk), .rst(rst), .bank_ld(bank_ld), .bank_bits(bank_bits),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rd_data(rd_data), .sfr_valid(sfr_valid), .sfr_ready(sfr_ready),
    .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_bit(sfr_bit),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] m, input logic [7:0] a, input logic w,
                     input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    req_valid = 1; req_mode = m; req_addr = a; req_we = w; req_wdata = d;
    #1;
    r = rd_data; s_valid = sfr_valid; s_addr = sfr_addr; s_we = sfr_we;
    s_bit = sfr_bit; s_wdata = sfr_wdata; s_ready = req_ready;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_we = 0;
  endtask

  task automatic setbank(input logic [1:0] b);
    @(negedge clk);
    req_valid = 0; req_we = 0; bank_ld = 1; bank_bits = b;
    @(negedge clk);
    bank_ld = 0; bank_bits = ~b;
  endtask

  function automatic logic [7:0] fill(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  initial begin
    logic [7:0] r;
    int hits0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: direct sweep of the lower half
    for (int a = 0; a < 128; a++) acc(2'b00, 8'(a), 1, fill(a), r);
    for (int a = 0; a < 128; a++) begin
      acc(2'b00, 8'(a), 0, 8'h00, r);
      check("R1 direct lower read", r, fill(a));
    end

    // R3: reset clears bank only
    setbank(2'd3);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    acc(2'b11, 8'h00, 1, 8'hAA, r);
    acc(2'b00, 8'h00, 0, 8'h00, r);
    check("R3 bank 0 after reset", r, 8'hAA);
    acc(2'b00, 8'h18, 0, 8'h00, r);
    check("R3 bank 3 R0 untouched", r, fill(8'h18));
    acc(2'b00, 8'h50, 0, 8'h00, r);
    check("R3 RAM kept over reset", r, fill(8'h50));

    // R2: every bank and register, upper address bits ignored
    for (int b = 0; b < 4; b++) begin
      setbank(2'(b));
      for (int n = 0; n < 8; n++)
        acc(2'b11, 8'(8'hA8 | n), 1, 8'(8'h80 + b * 16 + n), r);
    end
    setbank(2'd0);
    for (int i = 0; i < 32; i++) begin
      acc(2'b00, 8'(i), 0, 8'h00, r);
      check("R2 register to bank byte", r, 8'(8'h80 + (i / 8) * 16 + (i % 8)));
    end
    setbank(2'd2);
    for (int n = 0; n < 8; n++) begin
      acc(2'b11, 8'(n), 0, 8'h00, r);
      check("R2 register read bank 2", r, 8'(8'hA0 + n));
    end

    // R4: R1 of bank 2 as pointer into lower RAM, R0 as write pointer
    acc(2'b11, 8'h01, 1, 8'h40, r);
    acc(2'b01, 8'hFF, 0, 8'h00, r);
    check("R4 indirect via R1", r, fill(8'h40));
    acc(2'b11, 8'h00, 1, 8'h60, r);
    acc(2'b01, 8'hFE, 1, 8'h77, r);
    acc(2'b00, 8'h60, 0, 8'h00, r);
    check("R4 indirect write via R0", r, 8'h77);

    // R4: upper half through the pointer, no forwarding
    setbank(2'd1);
    hits0 = sfr_hits;
    for (int a = 128; a < 256; a++) begin
      acc(2'b11, 8'h00, 1, 8'(a), r);
      acc(2'b01, 8'h00, 1, 8'(a * 3), r);
    end
    for (int a = 128; a < 256; a++) begin
      acc(2'b11, 8'h00, 1, 8'(a), r);
      acc(2'b01, 8'h00, 0, 8'h00, r);
      check("R4 indirect upper read", r, 8'(a * 3));
    end
    idle();
    check("R4 no forwarded access", 8'(sfr_hits - hits0), 8'h00);

    // R5: direct upper goes to the register bus only
    for (int a = 128; a < 256; a++) begin
      acc(2'b00, 8'(a), 1, 8'(a + 7), r);
      check("R5 fwd write valid", {7'b0, s_valid}, 8'h01);
      check("R5 fwd write addr", s_addr, 8'(a));
      check("R5 fwd write flag", {7'b0, s_we}, 8'h01);
      check("R5 fwd write data", s_wdata, 8'(a + 7));
      acc(2'b00, 8'(a), 0, 8'h00, r);
      check("R5 fwd read data", r, ~8'(a));
    end
    for (int a = 128; a < 256; a++) begin
      acc(2'b11, 8'h00, 1, 8'(a), r);
      acc(2'b01, 8'h00, 0, 8'h00, r);
      check("R5 upper RAM untouched", r, 8'(a * 3));
    end

    // R6/R7: every RAM bit address
    for (int k = 0; k < 16; k++) begin
      mdl[k] = 8'(k * 29 + 3);
      acc(2'b00, 8'(32 + k), 1, mdl[k], r);
    end
    for (int b = 0; b < 128; b++) begin
      int byt, idx, nb;
      logic v;
      byt = b / 8; idx = b % 8; nb = (byt + 1) % 16;
      v = ((b / 3) % 2) == 1;
      mdl[byt] = 8'(b * 37);
      acc(2'b00, 8'(32 + byt), 1, mdl[byt], r);
      acc(2'b10, 8'(b), 1, {7'b1010101 ^ 7'(b), v}, r);
      mdl[byt][idx] = v;
      acc(2'b10, 8'(b), 0, 8'h00, r);
      check("R6 bit read", r, {7'b0, v});
      acc(2'b10, 8'(b ^ 1), 0, 8'h00, r);
      check("R7 neighbour bit", r, {7'b0, mdl[byt][idx ^ 1]});
      acc(2'b00, 8'(32 + byt), 0, 8'h00, r);
      check("R7 containing byte", r, mdl[byt]);
      acc(2'b00, 8'(32 + nb), 0, 8'h00, r);
      check("R7 next byte", r, mdl[nb]);
    end

    // R8: bit addresses in the upper half are forwarded
    for (int b = 128; b < 256; b++) begin
      acc(2'b10, 8'(b), 1, 8'h01, r);
      check("R8 fwd bit valid", {6'b0, s_valid, s_bit}, 8'h03);
      check("R8 fwd bit addr", s_addr, 8'(b));
    end
    for (int k = 0; k < 16; k++) begin
      acc(2'b00, 8'(32 + k), 0, 8'h00, r);
      check("R8 bit window untouched", r, mdl[k]);
    end

    // R9: back-pressure and idle
    sfr_ready = 0;
    acc(2'b00, 8'h90, 0, 8'h00, r);
    check("R9 fwd stalls", {7'b0, s_ready}, 8'h00);
    acc(2'b00, 8'h70, 0, 8'h00, r);
    check("R9 local accepted", {7'b0, s_ready}, 8'h01);
    sfr_ready = 1;
    acc(2'b00, 8'h90, 0, 8'h00, r);
    check("R9 fwd accepted", {7'b0, s_ready}, 8'h01);
    @(negedge clk);
    req_valid = 0; req_mode = 2'b00; req_addr = 8'h70; req_we = 1; req_wdata = 8'hEE;
    #1;
    check("R9 idle no fwd", {7'b0, sfr_valid}, 8'h00);
    acc(2'b00, 8'h70, 0, 8'h00, r);
    check("R9 idle no write", r, fill(8'h70));
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule